// File: doc/BRIEF.md
# ALU result output stage

This block is the final, purely combinational stage of a 64-bit integer ALU pipeline. It receives the raw result from the arithmetic and logic stages, two carry flags and an operation-context record. It applies an optional bitwise inversion to the result. It then derives a 4-bit condition field that says whether the delivered value, read as two's complement, is negative, positive or zero.

Compare operations reach this stage as the difference b minus a, not a minus b. For those operations the greater-than and less-than positions of the condition field are exchanged. This gives the flags the meaning of a compare of a against b.

The carry flags and every field of the context record pass through untouched, so that later stages see the same operation description. Arithmetic, overflow detection and writeback happen elsewhere.

Top module: `alu_out_stage`

## Requirements
- R1: When `inv_i` is 1, `res_o` equals the bitwise complement of `res_i`.
- R2: When `inv_i` is 0, `res_o` equals `res_i`.
- R3: Exactly one of `cond_o[3]`, `cond_o[2]` and `cond_o[1]` is 1 for every input.
- R4: When `res_o` is zero, `cond_o` is 4'b0010.
- R5: When `res_o` is positive (bit 63 clear and nonzero) and `op_i` is not the compare code 4'd2, `cond_o` is 4'b0100.
- R6: When `res_o` is positive and `op_i` is the compare code 4'd2, `cond_o` is 4'b1000.
- R7: When `res_o` is negative (bit 63 set) and `op_i` is not 4'd2, `cond_o` is 4'b1000.
- R8: When `res_o` is negative and `op_i` is 4'd2, `cond_o` is 4'b0100.
- R9: The classification uses the result after inversion. For example, `res_i` all ones with `inv_i` 1 gives `cond_o` 4'b0010.
- R10: `cond_o[0]` is always 0.
- R11: `carry_o` equals `carry_i` and `carry32_o` equals `carry32_i`.
- R12: `op_o`, `inv_o`, `tag_o` and `aux_o` equal `op_i`, `inv_i`, `tag_i` and `aux_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| res_i | input | 64 | Raw ALU result |
| carry_i | input | 1 | Carry out of the full-width operation |
| carry32_i | input | 1 | Carry out of the low 32 bits |
| op_i | input | 4 | Operation type code; 4'd2 means compare |
| inv_i | input | 1 | Invert-result flag from the context |
| tag_i | input | 2 | Pipeline tag carried in the context |
| aux_i | input | 8 | Further context bits, passed through |
| res_o | output | 64 | Final result |
| cond_o | output | 4 | Condition field: [3] lt/gt, [2] gt/lt, [1] zero, [0] always 0 |
| carry_o | output | 1 | Forwarded carry |
| carry32_o | output | 1 | Forwarded 32-bit carry |
| op_o | output | 4 | Forwarded operation type |
| inv_o | output | 1 | Forwarded invert flag |
| tag_o | output | 2 | Forwarded tag |
| aux_o | output | 8 | Forwarded further context bits |

## Verification
The result is tried with zero, small and large positive values, the most negative value, minus one and pseudo-random words. Each value is applied with and without inversion, under a compare code and under several non-compare codes. The zero and sign-boundary values distinguish a zero test from a sign test. The compare and non-compare pairs expose whether the greater-than and less-than positions are exchanged. Inverting all ones and zero shows whether the flags follow the delivered value or the raw one. Random context and carry patterns show that each forwarded field is wired to its own output.

// File: rtl/alu_out_pkg.sv
package alu_out_pkg;

    localparam int DATA_W = 64;
    localparam int OP_W   = 4;
    localparam int COND_W = 4;

    // Operation type codes carried in the context record.
    typedef enum logic [OP_W-1:0] {
        OPK_NONE  = 4'd0,
        OPK_ADD   = 4'd1,
        OPK_CMP   = 4'd2,
        OPK_LOGIC = 4'd3,
        OPK_SHIFT = 4'd4,
        OPK_MUL   = 4'd5
    } op_kind_e;

    // Condition field bit positions.
    localparam int CB_HI   = 3;
    localparam int CB_MID  = 2;
    localparam int CB_ZERO = 1;
    localparam int CB_SO   = 0;

    // Sign classification of a result.
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_POS  = 2'd1,
        CLS_NEG  = 2'd2
    } sign_cls_e;

    function automatic logic is_compare(input logic [OP_W-1:0] op);
        return op == OPK_CMP;
    endfunction

    // Maps a sign class to the condition field; compare swaps the order flags.
    function automatic logic [COND_W-1:0] cond_of(input sign_cls_e cls, input logic swap);
        logic [COND_W-1:0] c;
        c = '0;
        unique case (cls)
            CLS_ZERO: c[CB_ZERO] = 1'b1;
            CLS_POS:  if (swap) c[CB_HI]  = 1'b1; else c[CB_MID] = 1'b1;
            default:  if (swap) c[CB_MID] = 1'b1; else c[CB_HI]  = 1'b1;
        endcase
        c[CB_SO] = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/alu_out_invert.sv
module alu_out_invert #(
    parameter int W = 64
) (
    input  logic [W-1:0] din,
    input  logic         flip,
    output logic [W-1:0] dout
);
    logic [W-1:0] mask;
    assign mask = {W{flip}};
    assign dout = din ^ mask;
endmodule

// File: rtl/alu_out_classify.sv
module alu_out_classify
    import alu_out_pkg::*;
#(
    parameter int W = 64,
    parameter int LANE_W = 8
) (
    input  logic [W-1:0]      val,
    input  logic [OP_W-1:0]   op,
    output logic [COND_W-1:0] cond
);
    localparam int LANES = (W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    logic [PAD_W-1:0] padded;
    logic [LANES-1:0] lane_nz;
    sign_cls_e        cls;

    assign padded = PAD_W'(val);

    // Per-lane nonzero detection, then a final OR across lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_nz[g] = |padded[g*LANE_W +: LANE_W];
    end

    always_comb begin
        if (lane_nz == '0)      cls = CLS_ZERO;
        else if (val[W-1])      cls = CLS_NEG;
        else                    cls = CLS_POS;
    end

    assign cond = cond_of(cls, is_compare(op));
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage
    import alu_out_pkg::*;
#(
    parameter int TAG_W = 2,
    parameter int AUX_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              carry_i,
    input  logic              carry32_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              inv_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [AUX_W-1:0]  aux_i,
    output logic [DATA_W-1:0] res_o,
    output logic [COND_W-1:0] cond_o,
    output logic              carry_o,
    output logic              carry32_o,
    output logic [OP_W-1:0]   op_o,
    output logic              inv_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [AUX_W-1:0]  aux_o
);
    logic [DATA_W-1:0] final_res;

    alu_out_invert #(.W(DATA_W)) u_inv (
        .din  (res_i),
        .flip (inv_i),
        .dout (final_res)
    );

    // Flags describe the value actually delivered.
    alu_out_classify #(.W(DATA_W), .LANE_W(8)) u_cls (
        .val  (final_res),
        .op   (op_i),
        .cond (cond_o)
    );

    assign res_o     = final_res;
    assign carry_o   = carry_i;
    assign carry32_o = carry32_i;
    assign op_o      = op_i;
    assign inv_o     = inv_i;
    assign tag_o     = tag_i;
    assign aux_o     = aux_i;
endmodule

// File: rtl/alu_out_stage_chk.sv
module alu_out_stage_chk #(
    parameter int TAG_W = 2,
    parameter int AUX_W = 8
) (
    input logic [63:0]      res_i,
    input logic             carry_i,
    input logic             carry32_i,
    input logic [3:0]       op_i,
    input logic             inv_i,
    input logic [TAG_W-1:0] tag_i,
    input logic [AUX_W-1:0] aux_i,
    input logic [63:0]      res_o,
    input logic [3:0]       cond_o,
    input logic             carry_o,
    input logic             carry32_o,
    input logic [3:0]       op_o,
    input logic             inv_o,
    input logic [TAG_W-1:0] tag_o,
    input logic [AUX_W-1:0] aux_o
);
    logic cmp;
    assign cmp = (op_i == 4'd2);

    always_comb begin
        if (inv_i) p_invert_r1: assert (res_o == ~res_i);
        else       p_pass_r2:   assert (res_o == res_i);
        p_onehot_r3: assert ($countones(cond_o[3:1]) == 1);
        if (res_o == 64'd0) p_zero_r4: assert (cond_o == 4'b0010);
        if (res_o != 64'd0 && !res_o[63] && !cmp) p_pos_r5: assert (cond_o == 4'b0100);
        if (res_o != 64'd0 && !res_o[63] &&  cmp) p_poscmp_r6: assert (cond_o == 4'b1000);
        if (res_o[63] && !cmp) p_neg_r7: assert (cond_o == 4'b1000);
        if (res_o[63] &&  cmp) p_negcmp_r8: assert (cond_o == 4'b0100);
        if (inv_i && res_i == '1) p_postinv_r9: assert (cond_o[1]);
        p_so_low_r10: assert (!cond_o[0]);
        p_carry_r11: assert (carry_o == carry_i && carry32_o == carry32_i);
        p_ctx_r12: assert (op_o == op_i && inv_o == inv_i && tag_o == tag_i && aux_o == aux_i);
    end
endmodule

bind alu_out_stage alu_out_stage_chk #(.TAG_W(TAG_W), .AUX_W(AUX_W)) u_chk (
    .res_i(res_i), .carry_i(carry_i), .carry32_i(carry32_i), .op_i(op_i),
    .inv_i(inv_i), .tag_i(tag_i), .aux_i(aux_i), .res_o(res_o), .cond_o(cond_o),
    .carry_o(carry_o), .carry32_o(carry32_o), .op_o(op_o), .inv_o(inv_o),
    .tag_o(tag_o), .aux_o(aux_o)
);

// File: tb/alu_out_stage_tb.sv
`timescale 1ns/1ps
module alu_out_stage_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [63:0] res_i = '0;
    logic        carry_i = 1'b0, carry32_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        inv_i = 1'b0;
    logic [1:0]  tag_i = '0;
    logic [7:0]  aux_i = '0;
    logic [63:0] res_o;
    logic [3:0]  cond_o, op_o;
    logic        carry_o, carry32_o, inv_o;
    logic [1:0]  tag_o;
    logic [7:0]  aux_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    alu_out_stage u_dut (
        .res_i(res_i), .carry_i(carry_i), .carry32_i(carry32_i), .op_i(op_i),
        .inv_i(inv_i), .tag_i(tag_i), .aux_i(aux_i), .res_o(res_o), .cond_o(cond_o),
        .carry_o(carry_o), .carry32_o(carry32_o), .op_o(op_o), .inv_o(inv_o),
        .tag_o(tag_o), .aux_o(aux_o)
    );

    localparam logic [3:0] CMP = 4'd2;

    function automatic logic [3:0] exp_cond(input logic [63:0] v, input logic [3:0] op);
        if (v == 64'd0) return 4'b0010;
        if (!v[63]) return (op == CMP) ? 4'b1000 : 4'b0100;
        return (op == CMP) ? 4'b0100 : 4'b1000;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] r, input logic [3:0] op, input logic inv);
        @(negedge clk);
        res_i = r; op_i = op; inv_i = inv;
        #1;
    endtask

    task automatic t_reset_state();
        @(negedge clk); #1;
        chk("R4 reset res", res_o, 64'd0);
        chk("R4 reset cond", {60'd0, cond_o}, 64'h2);
        chk("R10 reset so", {63'd0, cond_o[0]}, 64'd0);
    endtask

    task automatic t_passthru();
        apply(64'h0123_4567_89AB_CDEF, 4'd1, 1'b0);
        chk("R2 pass", res_o, 64'h0123_4567_89AB_CDEF);
        chk("R5 pos add", {60'd0, cond_o}, 64'h4);
        apply(64'h8000_0000_0000_0000, 4'd3, 1'b0);
        chk("R2 pass min", res_o, 64'h8000_0000_0000_0000);
        chk("R7 neg logic", {60'd0, cond_o}, 64'h8);
        apply(64'd1, 4'd4, 1'b0);
        chk("R5 pos one", {60'd0, cond_o}, 64'h4);
    endtask

    task automatic t_invert();
        apply(64'h00FF_00FF_00FF_00FF, 4'd1, 1'b1);
        chk("R1 invert", res_o, 64'hFF00_FF00_FF00_FF00);
        chk("R7 neg after inv", {60'd0, cond_o}, 64'h8);
        apply('1, 4'd1, 1'b1);
        chk("R9 ones inverted", {60'd0, cond_o}, 64'h2);
        apply(64'd0, 4'd1, 1'b1);
        chk("R9 zero inverted", {60'd0, cond_o}, 64'h8);
        apply(64'h8000_0000_0000_0000, CMP, 1'b1);
        chk("R6 cmp pos after inv", {60'd0, cond_o}, 64'h8);
    endtask

    task automatic t_compare();
        apply(64'd5, CMP, 1'b0);
        chk("R6 cmp pos", {60'd0, cond_o}, 64'h8);
        apply(64'hFFFF_FFFF_FFFF_FFFF, CMP, 1'b0);
        chk("R8 cmp neg", {60'd0, cond_o}, 64'h4);
        apply(64'd0, CMP, 1'b0);
        chk("R4 cmp zero", {60'd0, cond_o}, 64'h2);
        apply(64'h7FFF_FFFF_FFFF_FFFF, CMP, 1'b0);
        chk("R6 cmp max", {60'd0, cond_o}, 64'h8);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 4'd5, 1'b0);
        chk("R7 neg mul", {60'd0, cond_o}, 64'h8);
    endtask

    task automatic t_forward();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            carry_i = i[0]; carry32_i = i[1];
            tag_i = 2'(i); aux_i = 8'(8'hA5 ^ (i * 37));
            inv_i = i[2]; op_i = 4'(i + 3);
            #1;
            chk("R11 carry", {63'd0, carry_o}, {63'd0, i[0]});
            chk("R11 carry32", {63'd0, carry32_o}, {63'd0, i[1]});
            chk("R12 ctx", {49'd0, op_o, inv_o, tag_o, aux_o},
                {49'd0, 4'(i + 3), i[2], 2'(i), 8'(8'hA5 ^ (i * 37))});
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [63:0] r;
            logic [3:0]  op;
            logic        inv;
            logic [63:0] v;
            r   = {$urandom, $urandom};
            if (i % 7 == 0) r = r & 64'h0000_0000_0000_FFFF;
            op  = (i % 2 == 0) ? CMP : 4'($urandom_range(5, 0));
            inv = 1'($urandom);
            v   = inv ? ~r : r;
            apply(r, op, inv);
            chk(inv ? "R1 rnd" : "R2 rnd", res_o, v);
            chk("R3 R5 R6 R7 R8 rnd cond", {60'd0, cond_o}, {60'd0, exp_cond(v, op)});
            chk("R3 onehot", 64'($countones(cond_o[3:1])), 64'd1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_passthru();
        t_invert();
        t_compare();
        t_forward();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule